// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator

This block collects event pulses from several hardware sources into a sticky status register and drives a single interrupt request. Each status bit, once set, stays set until software clears it. Software can also set any bit itself. One bit is reserved for software alone and can be used to test the interrupt path.

Software reaches the block through a simple register port. It has a write strobe, a two-bit address, write data, and combinational read data. The status register can only be read. The enable register can be read and written. The set and clear registers can only be written. Because hardware sources can only raise bits, software is the only agent that lowers them. A hardware event that meets a software clear in the same cycle is kept, so no event is lost.

Top module: `irq_agg`

## Requirements
- R1: After reset, every status bit and every enable bit is 0 and `irq` is low.
- R2: A 1 on `hw_evt[i]`, for any bit i other than the software bit, sets status bit i at the next clock edge. The bit then stays 1 after the input returns to 0.
- R3: The `hw_evt` inputs never clear a status bit.
- R4: A write to address 2 (set register) makes status 1 at the next edge for every bit where `reg_wdata` is 1. Bits where the write data is 0 are left unchanged.
- R5: A write to address 3 (clear register) makes status 0 at the next edge for every bit where `reg_wdata` is 1. Bits where the write data is 0 are left unchanged.
- R6: Status bit `SW_BIT` (default: the top bit) is never set by `hw_evt`. Only a set-register write can raise it.
- R7: If a hardware event and a clear write hit the same bit in the same cycle, that bit is 1 after the edge.
- R8: `irq` is 1 exactly when at least one status bit and its matching enable bit are both 1.
- R9: Register map:
  - Address 0 reads status, and writes to it are ignored.
  - Address 1 reads and writes enable.
  - Addresses 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_evt | input | N_BITS | Hardware event pulses, one per status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 enable, 2 set, 3 clear) |
| reg_wdata | input | N_BITS | Register write data |
| reg_rdata | output | N_BITS | Read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with `N_BITS` = 6 and the software bit at position 5. This keeps every status pattern easy to read while keeping a software-only bit that sits apart from the five hardware bits. With this narrow width, the bench can drive an event on the software-only bit, collide a clear with an event on the same bit, and mask the request down to one enabled bit. It can then read every register back through the port after each step.

// File: rtl/irq_agg.sv
module irq_agg #(
  parameter int N_BITS = 8,
  parameter int SW_BIT = N_BITS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] hw_evt,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [N_BITS-1:0] reg_wdata,
  output logic [N_BITS-1:0] reg_rdata,
  output logic              irq
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_SET  = 2'd2;
  localparam logic [1:0] A_CLR  = 2'd3;
  localparam logic [N_BITS-1:0] HW_MASK = ~(N_BITS'(1) << SW_BIT);

  logic [N_BITS-1:0] status_q, en_q;
  logic [N_BITS-1:0] set_m, clr_m, hw_m;

  assign set_m = (reg_wr && reg_addr == A_SET) ? reg_wdata : '0;
  assign clr_m = (reg_wr && reg_addr == A_CLR) ? reg_wdata : '0;
  assign hw_m  = hw_evt & HW_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= '0;
    end else begin
      status_q <= (status_q & ~clr_m) | set_m | hw_m;
      if (reg_wr && reg_addr == A_EN) en_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = status_q;
      A_EN:    reg_rdata = en_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(status_q & en_q);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int N_BITS = 8,
  parameter int SW_BIT = N_BITS - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_BITS-1:0] hw_evt,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [N_BITS-1:0] reg_wdata,
  input logic              irq,
  input logic [N_BITS-1:0] status,
  input logic [N_BITS-1:0] enable
);
  localparam logic [N_BITS-1:0] HW_ONLY = ~(N_BITS'(1) << SW_BIT);
  logic [N_BITS-1:0] c_set, c_clr, c_hw;
  assign c_set = (reg_wr && reg_addr == 2'd2) ? reg_wdata : '0;
  assign c_clr = (reg_wr && reg_addr == 2'd3) ? reg_wdata : '0;
  assign c_hw  = hw_evt & HW_ONLY;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (status == '0 && enable == '0));
  p_hw_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(c_hw)) == $past(c_hw)));
  p_no_hw_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~status & ~$past(c_clr)) == '0));
  p_set_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_set != '0) |=> ((status & $past(reg_wdata)) == $past(reg_wdata)));
  p_clear_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_clr != '0 && c_hw == '0 && c_set == '0) |=> ((status & $past(reg_wdata)) == '0));
  p_sw_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SW_BIT]) |-> $past(c_set[SW_BIT]));
  p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((c_hw & c_clr) != '0) |=> ((status & $past(c_hw & c_clr)) == $past(c_hw & c_clr)));
  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & enable) != '0));
endmodule

bind irq_agg irq_agg_chk #(.N_BITS(N_BITS), .SW_BIT(SW_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .status(status_q), .enable(en_q)
);

// File: tb/irq_agg_bench.sv
module irq_agg_bench;
  localparam int N = 6;
  localparam int SW = 5;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] hw_evt = '0, reg_wdata = '0, reg_rdata;
  logic reg_wr = 0, irq;
  logic [1:0] reg_addr = '0;

  irq_agg #(.N_BITS(N), .SW_BIT(SW)) u_irq_agg (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0, req = 0;
  logic [N-1:0] m_stat = '0, m_en = '0;
  logic [N:0] q_exp[$];
  string q_tag[$];

  task automatic op(input bit wr, input logic [1:0] a, input logic [N-1:0] d, input logic [N-1:0] hw);
    logic [N-1:0] hwm, setm, clrm;
    @(posedge clk); #2;
    req = 0; reg_wr = wr; reg_addr = a; reg_wdata = d; hw_evt = hw;
    hwm  = hw & ~(N'(1) << SW);
    setm = (wr && a == 2'd2) ? d : '0;
    clrm = (wr && a == 2'd3) ? d : '0;
    m_stat = (m_stat & ~clrm) | setm | hwm;
    if (wr && a == 2'd1) m_en = d;
  endtask

  task automatic chk(input logic [1:0] a, input string tag);
    logic [N-1:0] v;
    @(posedge clk); #2;
    reg_wr = 0; hw_evt = '0; reg_addr = a;
    v = (a == 2'd0) ? m_stat : (a == 2'd1) ? m_en : '0;
    q_exp.push_back({|(m_stat & m_en), v});
    q_tag.push_back(tag);
    req = 1;
  endtask

  always @(negedge clk) if (req && q_exp.size() > 0) begin
    logic [N:0] e;
    string t;
    e = q_exp.pop_front();
    t = q_tag.pop_front();
    checks++;
    if ({irq, reg_rdata} !== e) begin
      fails++;
      $display("FAIL %s: got irq=%b data=%h, expected irq=%b data=%h", t, irq, reg_rdata, e[N], e[N-1:0]);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk(0, "R1 status"); chk(1, "R1 enable");
    op(0, 0, '0, 6'b000101); chk(0, "R2 event sets");
    op(0, 0, '0, '0);        chk(0, "R2/R3 sticky");
    op(0, 0, '0, 6'b100000); chk(0, "R6 sw bit hw");
    op(1, 2, 6'b100000, '0); chk(0, "R4 set sw bit");
    op(1, 2, '0, '0);        chk(0, "R4 zero set");
    op(1, 3, 6'b000001, '0); chk(0, "R5 clear");
    op(1, 3, '0, '0);        chk(0, "R5 zero clear");
    op(1, 3, 6'b000100, 6'b000100); chk(0, "R7 collide");
    op(1, 1, 6'b000010, '0); chk(1, "R8/R9 enable masked");
    op(1, 1, 6'b100000, '0); chk(1, "R8 enable hits");
    op(1, 0, 6'b111111, '0); chk(0, "R9 status write ignored");
    chk(2, "R9 set reads 0"); chk(3, "R9 clear reads 0");
    op(1, 3, 6'b111111, 6'b010000); chk(0, "R7 collide all");
    op(1, 1, 6'b001111, '0); chk(1, "R8 no overlap");
    op(0, 0, '0, 6'b001000); chk(0, "R8 event raises irq");
    @(posedge clk); @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule